// File: doc/BRIEF.md
# Ramped FSK Frequency Sweep Generator

This block generates a frequency tuning word that glides between a lower frequency and an upper frequency, instead of jumping between them. A single FSK level input chooses the target. When that input is high, the output climbs toward the upper frequency. When it is low, the output falls toward the lower one. Every level change on the FSK input starts a programmable step timer. Each pulse from that timer moves an offset register by one delta step. The output tuning word is the lower frequency plus this offset.

The offset is clamped to the range from zero to the span between the two frequencies. A last step that would overshoot the target lands exactly on it, and the step timer then stops. The output holds the target for as long as the FSK level stays the same. If the FSK level flips during a sweep, the sweep turns around from the current frequency with no jump. The delta word and the step period can be rewritten during a sweep to build piecewise, non-linear profiles. A 48-bit phase accumulator follows the tuning word and produces the instantaneous phase.

Top module: `ramp_fsk_gen`

## Requirements
- R1: While reset is asserted, the tuning output equals the lower frequency input (offset zero), the phase output is zero and busy is low.
- R2: A change in the FSK level, seen at a clock edge, sets busy high from the next cycle; busy never rises without such a change.
- R3: With step period value N (legal range 1 to 2^20-1), the first step lands N+1 clock edges after the edge that detected the FSK change, and each later step follows N+1 edges after the previous one.
- R4: While FSK is high, each step adds the delta word (a positive 48-bit unsigned value) to the offset, and the tuning output equals the lower frequency plus the offset.
- R5: While rising, a step that would reach or pass the span (upper minus lower frequency) sets the offset to exactly the span, and busy drops at that same edge.
- R6: While FSK is low, each step removes the delta word from the offset; a step that would reach or pass zero sets the offset to exactly zero, and busy drops at that same edge.
- R7: An FSK change during a sweep reverses the direction from the current offset without changing the tuning output, and it restarts the step timer at a full N+1 period.
- R8: While busy is low and the FSK level is held, the tuning output stays constant.
- R9: While the clear input is high, the offset is forced to zero (tuning equals the lower frequency) and steps have no effect; after the clear input drops, the sweep continues from zero.
- R10: On every clock edge the phase output advances by the tuning output, modulo 2^48.
- R11: A new delta word applies from the next step, and a new step period value applies from the next timer reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fsk_i | input | 1 | Target select: high sweeps up, low sweeps down |
| f_low_i | input | 48 | Lower frequency tuning word |
| f_high_i | input | 48 | Upper frequency tuning word |
| delta_i | input | 48 | Step size added to or removed from the offset, positive |
| rate_i | input | 20 | Step period value N; steps are N+1 cycles apart |
| acc_clr_i | input | 1 | Forces the frequency offset to zero while high |
| tuning_o | output | 48 | Current frequency tuning word |
| phase_o | output | 48 | Instantaneous phase from the phase accumulator |
| busy_o | output | 1 | High while the step timer runs |

## Verification
The bench aims at the final step of each sweep. There, a clamp that fails would overshoot the upper frequency or wrap below the lower one, and a busy flag that stops late would give one extra step. It flips FSK in the middle of a sweep to catch a design that jumps back to an endpoint or keeps the old count running. It checks step spacing at two period values and changes the period and the delta in the middle of a ramp, so an off-by-one reload or a delayed update of a value shows up in the tuning word. It also pulses the clear input during a sweep and runs the phase accumulator through a wrap of its 48-bit range.

// File: rtl/rfsk_pkg.sv
package rfsk_pkg;
  localparam int FREQ_W = 48;
  localparam int RATE_W = 20;

  typedef enum logic {
    SWEEP_DOWN = 1'b0,
    SWEEP_UP   = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/rfsk_rst_sync.sv
module rfsk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rfsk_step_timer.sv
module rfsk_step_timer #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              step_o,
  output logic              busy_o
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              run_q, run_d;
  logic              cnt_en;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  // a fresh FSK edge suppresses the pending step and restarts the period
  assign step_o  = run_q & at_zero & ~start_i;
  assign busy_o  = run_q;
  assign cnt_en  = start_i | run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = rate_i;
    end else if (run_q) begin
      if (halt_i) run_d = 1'b0;
      if (at_zero) cnt_d = rate_i;
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/rfsk_freq_acc.sv
module rfsk_freq_acc
  import rfsk_pkg::*;
#(
  parameter int FREQ_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  sweep_dir_e        dir_i,
  input  logic [FREQ_W-1:0] delta_i,
  input  logic [FREQ_W-1:0] span_i,
  output logic [FREQ_W-1:0] off_o,
  output logic              arrive_o
);
  localparam int SUM_W = FREQ_W + 1;

  logic [FREQ_W-1:0] off_q, off_d, off_step;
  logic [SUM_W-1:0]  up_sum;
  logic              hit_up, hit_dn, hit;
  logic              off_en;

  assign up_sum = {1'b0, off_q} + {1'b0, delta_i};
  assign hit_up = (up_sum >= {1'b0, span_i});
  assign hit_dn = (delta_i >= off_q);

  always_comb begin
    if (dir_i == SWEEP_UP) begin
      hit      = hit_up;
      off_step = hit_up ? span_i : up_sum[FREQ_W-1:0];
    end else begin
      hit      = hit_dn;
      off_step = hit_dn ? '0 : (off_q - delta_i);
    end
  end

  assign arrive_o = step_i & hit;
  assign off_en   = clr_i | step_i;
  assign off_d    = clr_i ? '0 : off_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign off_o = off_q;
endmodule

// File: rtl/rfsk_phase_acc.sv
module rfsk_phase_acc #(
  parameter int FREQ_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] tuning_i,
  output logic [FREQ_W-1:0] phase_o
);
  logic [FREQ_W-1:0] phase_q, phase_d;

  assign phase_d = phase_q + tuning_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ramp_fsk_gen.sv
module ramp_fsk_gen
  import rfsk_pkg::*;
#(
  parameter int FREQ_W = rfsk_pkg::FREQ_W,
  parameter int RATE_W = rfsk_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsk_i,
  input  logic [FREQ_W-1:0] f_low_i,
  input  logic [FREQ_W-1:0] f_high_i,
  input  logic [FREQ_W-1:0] delta_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              acc_clr_i,
  output logic [FREQ_W-1:0] tuning_o,
  output logic [FREQ_W-1:0] phase_o,
  output logic              busy_o
);
  logic              rst_sync_n;
  logic              fsk_q;
  logic              fsk_edge;
  logic              step;
  logic              arrive;
  sweep_dir_e        dir;
  logic [FREQ_W-1:0] span;
  logic [FREQ_W-1:0] off;

  rfsk_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fsk_q <= 1'b0;
    else             fsk_q <= fsk_i;
  end

  assign fsk_edge = fsk_i ^ fsk_q;
  assign dir      = fsk_q ? SWEEP_UP : SWEEP_DOWN;
  assign span     = f_high_i - f_low_i;

  rfsk_step_timer #(.RATE_W(RATE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (fsk_edge),
    .halt_i  (arrive),
    .rate_i  (rate_i),
    .step_o  (step),
    .busy_o  (busy_o)
  );

  rfsk_freq_acc #(.FREQ_W(FREQ_W)) u_facc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (acc_clr_i),
    .step_i   (step),
    .dir_i    (dir),
    .delta_i  (delta_i),
    .span_i   (span),
    .off_o    (off),
    .arrive_o (arrive)
  );

  assign tuning_o = f_low_i + off;

  rfsk_phase_acc #(.FREQ_W(FREQ_W)) u_pacc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tuning_i (tuning_o),
    .phase_o  (phase_o)
  );
endmodule

// File: rtl/rfsk_checks.sv
module rfsk_checks #(
  parameter int FREQ_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsk_i,
  input logic              fsk_lvl,
  input logic              busy_o,
  input logic              step,
  input logic [FREQ_W-1:0] off,
  input logic [FREQ_W-1:0] f_low_i,
  input logic [FREQ_W-1:0] f_high_i,
  input logic              acc_clr_i,
  input logic [FREQ_W-1:0] tuning_o,
  input logic [FREQ_W-1:0] phase_o
);
  // R2: the timer only starts on a level change of FSK
  a_r2_busy_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(fsk_i) != $past(fsk_lvl)));

  // R8: no movement of the tuning word while idle
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy_o) && $stable(f_low_i) && !$past(acc_clr_i)) |-> $stable(tuning_o));

  // R5: a step never leaves the offset above the span
  a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && !$past(acc_clr_i) && $past(f_high_i >= f_low_i))
      |-> (off <= $past(f_high_i - f_low_i)));

  // R5 / R6: the timer only stops on an endpoint
  a_r6_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ((off == '0) || (off == $past(f_high_i - f_low_i))));

  // R10: phase advances by the tuning word each cycle
  a_r10_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (phase_o == $past(phase_o) + $past(tuning_o)));
endmodule

bind ramp_fsk_gen rfsk_checks #(.FREQ_W(FREQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .fsk_i     (fsk_i),
  .fsk_lvl   (fsk_q),
  .busy_o    (busy_o),
  .step      (step),
  .off       (off),
  .f_low_i   (f_low_i),
  .f_high_i  (f_high_i),
  .acc_clr_i (acc_clr_i),
  .tuning_o  (tuning_o),
  .phase_o   (phase_o)
);

// File: tb/tb_ramp_fsk_gen.sv
module tb_ramp_fsk_gen;
  localparam int FW = 48;
  localparam int RW = 20;

  logic          clk;
  logic          rst_n;
  logic          fsk;
  logic [FW-1:0] f_low, f_high, delta;
  logic [RW-1:0] rate;
  logic          clr;
  logic [FW-1:0] tuning, phase;
  logic          busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  ramp_fsk_gen dut (
    .clk(clk), .rst_n(rst_n), .fsk_i(fsk), .f_low_i(f_low), .f_high_i(f_high),
    .delta_i(delta), .rate_i(rate), .acc_clr_i(clr),
    .tuning_o(tuning), .phase_o(phase), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic          fsk;
    logic [FW-1:0] delta;
    logic [RW-1:0] rate;
    logic [7:0]    n_cyc;
    logic [FW-1:0] tune;
    logic          busy;
  } vec_t;

  // F1 = 1000, F2 = 1100 throughout the table
  localparam vec_t VEC [16] = '{
    '{1'b1, 48'd30, 20'd3, 8'd1,  48'd1000, 1'b1},  // R2 busy after edge
    '{1'b1, 48'd30, 20'd3, 8'd4,  48'd1030, 1'b1},  // R3 R4 first step
    '{1'b1, 48'd30, 20'd3, 8'd4,  48'd1060, 1'b1},  // R3 R4
    '{1'b1, 48'd30, 20'd3, 8'd4,  48'd1090, 1'b1},  // R4
    '{1'b1, 48'd30, 20'd3, 8'd4,  48'd1100, 1'b0},  // R5 clamp, stop
    '{1'b1, 48'd30, 20'd3, 8'd10, 48'd1100, 1'b0},  // R8 hold
    '{1'b0, 48'd30, 20'd3, 8'd5,  48'd1070, 1'b1},  // R6 down
    '{1'b0, 48'd30, 20'd3, 8'd4,  48'd1040, 1'b1},  // R6
    '{1'b1, 48'd30, 20'd3, 8'd2,  48'd1040, 1'b1},  // R7 reverse, no jump
    '{1'b1, 48'd30, 20'd3, 8'd3,  48'd1070, 1'b1},  // R7 full period restart
    '{1'b1, 48'd30, 20'd3, 8'd4,  48'd1100, 1'b0},  // R5
    '{1'b0, 48'd7,  20'd1, 8'd3,  48'd1093, 1'b1},  // R3 N=1
    '{1'b0, 48'd7,  20'd1, 8'd2,  48'd1086, 1'b1},  // R3
    '{1'b0, 48'd40, 20'd2, 8'd2,  48'd1046, 1'b1},  // R11 new delta
    '{1'b0, 48'd40, 20'd2, 8'd3,  48'd1006, 1'b1},  // R11 new period
    '{1'b0, 48'd40, 20'd2, 8'd3,  48'd1000, 1'b0}   // R6 clamp at zero
  };

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run incomplete");
    finish_run();
  end

  initial begin
    logic [FW-1:0] p1, tw;
    rst_n = 1'b0; fsk = 1'b0; clr = 1'b0;
    f_low = 48'd1000; f_high = 48'd1100; delta = 48'd30; rate = 20'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 tuning", tuning, 48'd1000);
    check("R1 phase", phase, '0);
    check("R1 busy", {47'b0, busy}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 phase advance while idle
    p1 = phase;
    repeat (5) @(negedge clk);
    check("R10 phase idle", phase, p1 + 48'd5000);

    for (int i = 0; i < 16; i++) begin
      fsk = VEC[i].fsk; delta = VEC[i].delta; rate = VEC[i].rate;
      repeat (VEC[i].n_cyc) @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d tuning R4-R7", i), tuning, VEC[i].tune);
      check($sformatf("vec%0d busy R2-R6", i), {47'b0, busy}, {47'b0, VEC[i].busy});
    end

    // R9 clear during a sweep
    delta = 48'd30; rate = 20'd3; fsk = 1'b1;
    repeat (9) @(posedge clk);
    @(negedge clk);
    check("R9 before clear", tuning, 48'd1060);
    clr = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 cleared", tuning, 48'd1000);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 steps ignored", tuning, 48'd1000);
    check("R9 timer still busy", {47'b0, busy}, 48'd1);
    clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 resumes from zero", tuning, 48'd1030);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R5 end after clear", tuning, 48'd1100);
    check("R5 idle after clear", {47'b0, busy}, '0);

    // R10 wrap of the phase accumulator, offset held at 100 (R8)
    f_low = 48'hC000_0000_0000; f_high = 48'hC000_0000_0000;
    tw = 48'hC000_0000_0064;
    @(negedge clk);
    check("R8 hold with new F1", tuning, tw);
    p1 = phase;
    repeat (3) @(negedge clk);
    check("R10 phase wrap", phase, p1 + tw + tw + tw);

    finish_run();
  end
endmodule